// File: doc/BRIEF.md
# Processor Bus and Peripheral Clock Divider

This block takes one parent clock and produces two slower processor-side clocks from it. The peripheral clock runs at a quarter or an eighth of the parent rate. The bus clock runs at a half, third, quarter or fifth of the parent rate. Both ratios come from a 3-bit control field, which a register elsewhere in the chip supplies. Each output is a registered clock level. Each output also has a one-cycle enable pulse, so that logic which stays on the parent clock can work at the divided rate.

Each divider keeps an active ratio. The active ratio is reloaded from the control field only at the boundary between two output periods, so a new setting never cuts a period short. For odd bus ratios the high phase is the shorter one. The bus divider runs from the moment reset is released and has no separate start control.

Top module: `cpu_clk_divider`

## Requirements
- R1: With control bit 0 at 0, the peripheral output has a period of exactly 4 parent cycles.
- R2: With control bit 0 at 1, the peripheral output has a period of exactly 8 parent cycles.
- R3: Control bits 2:1 hold an unsigned field N, and the bus output has a period of N + 2 parent cycles (2, 3, 4 or 5).
- R4: In each period of either output, the clock is high for floor(R/2) parent cycles and low for the remaining ceil(R/2) cycles, where R is the period. The low phase comes first.
- R5: Each output's enable pulse is high for exactly one parent cycle per period. That cycle is the last cycle of the period, so the clock is high then and low in the following cycle.
- R6: A change of the control field does not alter the period in progress. The new ratio applies from the next period boundary.
- R7: During reset both clocks and both enables are low. After release, the first period uses the default ratios of 4 (peripheral) and 2 (bus), so bus_en_o is high in the first cycle after the first clock edge and per_en_o in the third.
- R8: Both outputs count the same parent clock from the same reset. With ratios 4 and 2 from reset, every peripheral enable coincides with a bus enable: 4 peripheral and 8 bus enables in 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 3 | Bit 0: peripheral select (0 = /4, 1 = /8); bits 2:1: bus field N (ratio N+2) |
| per_clk_o | output | 1 | Divided peripheral clock level |
| per_en_o | output | 1 | One-cycle peripheral enable, once per period |
| bus_clk_o | output | 1 | Divided bus clock level |
| bus_en_o | output | 1 | One-cycle bus enable, once per period |

## Verification
All four outputs are registered, so each one reflects the state entered at the parent edge just before it. The bench samples at falling edges. After reset is released, the bus enable is due at the first sample and the peripheral enable at the third. In steady state, each period is measured from one enable pulse to the next, and the high cycles in that span are counted. A ratio change is applied one sample into a measured period, so the old ratio must still govern that period and the new ratio must govern the one after it.

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider #(
  parameter int PER_FAST = 4,
  parameter int PER_SLOW = 8,
  parameter int BUS_OFS  = 2,
  parameter int BUS_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W:0]   ctrl_i,
  output logic             per_clk_o,
  output logic             per_en_o,
  output logic             bus_clk_o,
  output logic             bus_en_o
);

  localparam int BUS_MAX = BUS_OFS + (1 << BUS_W) - 1;
  localparam int MAXR    = (PER_SLOW > BUS_MAX) ? PER_SLOW : BUS_MAX;
  localparam int CW      = $clog2(MAXR + 1);

  logic [CW-1:0] pr_q, pc_q, pr_d, pc_d;
  logic [CW-1:0] br_q, bc_q, br_d, bc_d;
  logic          p_wrap, b_wrap;

  // peripheral divider
  assign p_wrap = (pc_q == pr_q - CW'(1));
  assign pr_d   = p_wrap ? (ctrl_i[0] ? CW'(PER_SLOW) : CW'(PER_FAST)) : pr_q;
  assign pc_d   = p_wrap ? '0 : pc_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q      <= CW'(PER_FAST);
      pc_q      <= '0;
      per_clk_o <= 1'b0;
      per_en_o  <= 1'b0;
    end else begin
      pr_q      <= pr_d;
      pc_q      <= pc_d;
      per_clk_o <= (pc_d >= pr_d - (pr_d >> 1));
      per_en_o  <= (pc_d == pr_d - CW'(1));
    end
  end

  // bus divider
  assign b_wrap = (bc_q == br_q - CW'(1));
  assign br_d   = b_wrap ? CW'(BUS_OFS) + CW'(ctrl_i[BUS_W:1]) : br_q;
  assign bc_d   = b_wrap ? '0 : bc_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      br_q      <= CW'(BUS_OFS);
      bc_q      <= '0;
      bus_clk_o <= 1'b0;
      bus_en_o  <= 1'b0;
    end else begin
      br_q      <= br_d;
      bc_q      <= bc_d;
      bus_clk_o <= (bc_d >= br_d - (br_d >> 1));
      bus_en_o  <= (bc_d == br_d - CW'(1));
    end
  end

  p_per_en_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |-> per_clk_o);
  p_bus_en_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> bus_clk_o);
  p_per_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |=> (!per_clk_o && !per_en_o));
  p_bus_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |=> (!bus_clk_o && !bus_en_o));
  p_per_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_en_o |=> $stable(pr_q));
  p_bus_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_o |=> $stable(br_q));
  p_bus_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_q >= CW'(BUS_OFS)) && (br_q <= CW'(BUS_MAX)));

endmodule

// File: tb/sim_cpu_clk_divider.sv
module sim_cpu_clk_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ctrl = 3'b110;
  logic per_clk, per_en, bus_clk, bus_en;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_clk_divider u0 (.clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .per_clk_o(per_clk), .per_en_o(per_en), .bus_clk_o(bus_clk), .bus_en_o(bus_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic en_of(input bit bus);
    return bus ? bus_en : per_en;
  endfunction
  function automatic logic clk_of(input bit bus);
    return bus ? bus_clk : per_clk;
  endfunction

  task automatic wait_en(input bit bus);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (en_of(bus)) return;
    end
  endtask

  // measure one period from an enable pulse to the next
  task automatic measure(input bit bus, input int exp_r, input bit chg,
                         input logic [2:0] nctrl, input string req);
    int n = 0, h = 0, w = 0;
    bit first_low = 0;
    wait_en(bus);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      n++;
      if (clk_of(bus)) h++;
      if (en_of(bus)) w++;
      if (i == 0) begin
        first_low = !clk_of(bus);
        if (chg) ctrl = nctrl;
      end
      if (en_of(bus)) break;
    end
    chk(n == exp_r, {req, " period"}, n, exp_r);
    chk(h == exp_r / 2, "R4 high phase", h, exp_r / 2);
    chk(first_low, "R4 low phase first", first_low, 1);
    chk(w == 1, "R5 one enable per period", w, 1);
  endtask

  task automatic do_reset(input logic [2:0] c);
    rst_n = 1'b0;
    ctrl = c;
    repeat (3) @(negedge clk);
    chk({per_clk, per_en, bus_clk, bus_en} == 4'b0, "R7 reset outputs low",
        {per_clk, per_en, bus_clk, bus_en}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(3'b110);
    @(negedge clk);
    chk(bus_en == 1'b1, "R7 first bus enable", bus_en, 1);
    chk(per_en == 1'b0, "R7 per enable not yet", per_en, 0);
    @(negedge clk);
    @(negedge clk);
    chk(per_en == 1'b1, "R7 default per ratio 4", per_en, 1);
  endtask

  task automatic t_bus_ratios;
    for (int n = 0; n < 4; n++) begin
      ctrl = {n[1:0], 1'b0};
      wait_en(1'b1);
      wait_en(1'b1);
      measure(1'b1, n + 2, 1'b0, ctrl, "R3 bus");
    end
  endtask

  task automatic t_per_ratios;
    ctrl = 3'b000;
    wait_en(1'b0); wait_en(1'b0);
    measure(1'b0, 4, 1'b0, ctrl, "R1 per /4");
    ctrl = 3'b001;
    wait_en(1'b0); wait_en(1'b0);
    measure(1'b0, 8, 1'b0, ctrl, "R2 per /8");
  endtask

  task automatic t_change;
    ctrl = 3'b010;
    wait_en(1'b1); wait_en(1'b1);
    measure(1'b1, 3, 1'b1, 3'b110, "R6 bus old ratio kept");
    measure(1'b1, 5, 1'b0, 3'b110, "R6 bus new ratio");
    ctrl = 3'b001;
    wait_en(1'b0); wait_en(1'b0);
    measure(1'b0, 8, 1'b1, 3'b000, "R6 per old ratio kept");
    measure(1'b0, 4, 1'b0, 3'b000, "R6 per new ratio");
  endtask

  task automatic t_shared;
    int np = 0, nb = 0, miss = 0;
    do_reset(3'b000);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (per_en) np++;
      if (bus_en) nb++;
      if (per_en && !bus_en) miss++;
    end
    chk(np == 4, "R8 per enables in 16", np, 4);
    chk(nb == 8, "R8 bus enables in 16", nb, 8);
    chk(miss == 0, "R8 per enable aligned to bus", miss, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bus_ratios();
    t_per_ratios();
    t_change();
    t_shared();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule